// File: doc/BRIEF.md
# Dual-Clock Match Timer with Handshaked Register Access

This peripheral keeps a 32-bit up-counter in a slow timer clock domain and exposes it to a faster register bus. A compare register raises a sticky event flag when the running counter reaches the programmed value. An enable bit gates that flag onto an interrupt line. The bus never reads or writes the timer-domain registers directly. Each counter load, compare update and counter capture is carried across as a toggle request. The request is answered by a toggle acknowledge that returns through its own two-flop synchronizer.

Software drives the block by polling a busy-flag register. To read the count, it writes the control register with the capture bit set, waits for the capture flag to drop and then reads the counter offset. To program a compare value or load the counter, it writes the register and waits for the matching flag to clear before the value can be relied on. A second request of the same kind made while its flag is still up is dropped. The first transfer then finishes with its own data.

Top module: `sync_timer`

## Requirements
- R1: After reset the match register reads 0xFFFFFFFF. The control, status, interrupt-enable and access-status registers and the counter register (offset 0x10) all read 0.
- R2: While control bit 0 is 1, the counter adds one on every timer clock. While it is 0, the counter holds its value.
- R3: The counter wraps from 0xFFFFFFFF to 0.
- R4: A write to control (0x20) with bit 1 set requests a capture of the counter, and bit 0 of the same write sets the run enable. Access-status (0x24) bit 5 reads 1 from the cycle after the write until the capture is acknowledged. After that, a read of 0x10 returns the captured count.
- R5: A write to 0x10 loads the counter with the written value. Access-status bit 4 reads 1 from the next cycle until the load has been applied.
- R6: A write to 0x00 sets the compare value. Access-status bit 0 reads 1 from the next cycle until the value is committed, and a read of 0x00 returns the accepted value.
- R7: A compare write, counter load or capture request made while its own access-status bit is 1 is ignored. The earlier transfer completes with its original data.
- R8: Status (0x14) bit 0 becomes 1 when the counter holds the compare value on a timer clock while running. It stays 1 until cleared. Status bits 3:1 always read 0.
- R9: Writing status with bit 0 equal to 1 clears bit 0. Writing 0 there leaves it unchanged.
- R10: Interrupt-enable (0x1C) bit 0 gates the interrupt: `irq` is 1 exactly when status bit 0 and enable bit 0 are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bus | input | 1 | Register-bus clock |
| clk_tmr | input | 1 | Slow timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| bus_wr | input | 1 | Write strobe for one bus cycle |
| bus_rd | input | 1 | Read enable; read data is zero while low |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq | output | 1 | Match interrupt |

## Verification
The count is tried in three ways: stopped, where two captures far apart must agree; running, where the step between two captures must fit the clock ratio; and loaded just below the top value, where a small result shows the wrap. Compare events are driven with the interrupt enable both off and on, so the sticky flag can be told apart from the gated output. Back-to-back compare writes and back-to-back counter loads separate a dropped second request from one that overwrote the first: only the first value may take effect. On every bus clock, the bench compares the interrupt output against its own record of the enable bit.

// File: rtl/sync_timer_pkg.sv
`timescale 1ns/1ps
package sync_timer_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_MATCH  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_IRQEN  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_ACCESS = 6'h24;

  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam int unsigned CTRL_SNAP_BIT = 1;
  localparam int unsigned STAT_HIT_BIT  = 0;
  localparam int unsigned ACC_MATCH_BIT = 0;
  localparam int unsigned ACC_LOAD_BIT  = 4;
  localparam int unsigned ACC_SNAP_BIT  = 5;
endpackage

// File: rtl/st_rst_sync.sv
`timescale 1ns/1ps
module st_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/st_sync.sv
`timescale 1ns/1ps
module st_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;
  logic [STAGES-1:0][WIDTH-1:0] pipe_d;

  always_comb begin
    pipe_d[0] = d;
    for (int i = 1; i < STAGES; i++) pipe_d[i] = pipe_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/st_handoff.sv
`timescale 1ns/1ps
module st_handoff #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_req_i,
  output logic src_accept_o,
  output logic src_busy_o,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse_o
);
  logic req_tgl_q, req_tgl_d;
  logic ack_in_src;
  logic req_in_dst;
  logic seen_q;

  // source side: flip the request toggle only when idle
  assign src_busy_o   = req_tgl_q ^ ack_in_src;
  assign src_accept_o = src_req_i & ~src_busy_o;

  always_comb begin
    req_tgl_d = ~req_tgl_q;
  end

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n)        req_tgl_q <= 1'b0;
    else if (src_accept_o) req_tgl_q <= req_tgl_d;
  end

  st_sync #(.WIDTH(1), .STAGES(STAGES)) u_req_sync (
    .clk(dst_clk), .rst_n(dst_rst_n), .d(req_tgl_q), .q(req_in_dst)
  );

  // destination side: edge of the synchronized toggle is the commit pulse
  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) seen_q <= 1'b0;
    else            seen_q <= req_in_dst;
  end

  assign dst_pulse_o = req_in_dst ^ seen_q;

  st_sync #(.WIDTH(1), .STAGES(STAGES)) u_ack_sync (
    .clk(src_clk), .rst_n(src_rst_n), .d(seen_q), .q(ack_in_src)
  );

  assert_busy_after_accept_R6: assert property (
    @(posedge src_clk) disable iff (!src_rst_n)
    src_accept_o |=> src_busy_o);

  assert_single_commit_R7: assert property (
    @(posedge dst_clk) disable iff (!dst_rst_n)
    dst_pulse_o |=> !dst_pulse_o);
endmodule

// File: rtl/st_tick_core.sv
`timescale 1ns/1ps
module st_tick_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              cmp_load_i,
  input  logic [DATA_W-1:0] cmp_val_i,
  input  logic              snap_i,
  output logic [DATA_W-1:0] snap_o,
  output logic              hit_tgl_o
);
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] cmp_q;
  logic [DATA_W-1:0] snap_q;
  logic              hit_tgl_q;
  logic              cnt_en;
  logic              hit;

  always_comb begin
    cnt_en = load_i | run_i;
    cnt_d  = load_i ? load_val_i : cnt_q + 1'b1;
    hit    = run_i & (cnt_q == cmp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cmp_q <= '1;
    else if (cmp_load_i) cmp_q <= cmp_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      snap_q <= '0;
    else if (snap_i) snap_q <= cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hit_tgl_q <= 1'b0;
    else if (hit) hit_tgl_q <= ~hit_tgl_q;
  end

  assign snap_o    = snap_q;
  assign hit_tgl_o = hit_tgl_q;

  assert_step_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    (run_i && !load_i) |=> (cnt_q == DATA_W'($past(cnt_q) + 1'b1)));

  assert_hold_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    (!run_i && !load_i) |=> $stable(cnt_q));

  assert_wrap_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    (run_i && !load_i && cnt_q == '1) |=> (cnt_q == '0));

  assert_load_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/sync_timer.sv
`timescale 1ns/1ps
module sync_timer
  import sync_timer_pkg::*;
#(
  parameter int DW          = sync_timer_pkg::DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_bus,
  input  logic              clk_tmr,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);
  logic rst_bus_n, rst_tmr_n;

  st_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_bus (
    .clk(clk_bus), .arst_n(rst_n), .srst_n(rst_bus_n));
  st_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_tmr (
    .clk(clk_tmr), .arst_n(rst_n), .srst_n(rst_tmr_n));

  // decode
  logic wr_match, wr_count, wr_status, wr_irqen, wr_ctrl, snap_req;
  always_comb begin
    wr_match  = bus_wr && (bus_addr == OFS_MATCH);
    wr_count  = bus_wr && (bus_addr == OFS_COUNT);
    wr_status = bus_wr && (bus_addr == OFS_STATUS);
    wr_irqen  = bus_wr && (bus_addr == OFS_IRQEN);
    wr_ctrl   = bus_wr && (bus_addr == OFS_CTRL);
    snap_req  = wr_ctrl && bus_wdata[CTRL_SNAP_BIT];
  end

  // handoff channels
  logic match_acc, match_busy, match_commit;
  logic load_acc,  load_busy,  load_commit;
  logic snap_acc,  snap_busy,  snap_commit;

  st_handoff #(.STAGES(SYNC_STAGES)) u_xfer_match (
    .src_clk(clk_bus), .src_rst_n(rst_bus_n), .src_req_i(wr_match),
    .src_accept_o(match_acc), .src_busy_o(match_busy),
    .dst_clk(clk_tmr), .dst_rst_n(rst_tmr_n), .dst_pulse_o(match_commit));

  st_handoff #(.STAGES(SYNC_STAGES)) u_xfer_load (
    .src_clk(clk_bus), .src_rst_n(rst_bus_n), .src_req_i(wr_count),
    .src_accept_o(load_acc), .src_busy_o(load_busy),
    .dst_clk(clk_tmr), .dst_rst_n(rst_tmr_n), .dst_pulse_o(load_commit));

  st_handoff #(.STAGES(SYNC_STAGES)) u_xfer_snap (
    .src_clk(clk_bus), .src_rst_n(rst_bus_n), .src_req_i(snap_req),
    .src_accept_o(snap_acc), .src_busy_o(snap_busy),
    .dst_clk(clk_tmr), .dst_rst_n(rst_tmr_n), .dst_pulse_o(snap_commit));

  // bus-domain registers
  logic [DW-1:0] match_sh_q, load_sh_q;
  logic          run_q, run_d;
  logic          irqen_q, irqen_d;
  logic          stat_q, stat_d;
  logic          evt_sync, evt_prev_q, evt_pulse;

  always_ff @(posedge clk_bus or negedge rst_bus_n) begin
    if (!rst_bus_n)     match_sh_q <= '1;
    else if (match_acc) match_sh_q <= bus_wdata;
  end

  always_ff @(posedge clk_bus or negedge rst_bus_n) begin
    if (!rst_bus_n)    load_sh_q <= '0;
    else if (load_acc) load_sh_q <= bus_wdata;
  end

  always_comb begin
    run_d   = bus_wdata[CTRL_RUN_BIT];
    irqen_d = bus_wdata[0];
    evt_pulse = evt_sync ^ evt_prev_q;
    stat_d  = stat_q;
    if (wr_status && bus_wdata[STAT_HIT_BIT]) stat_d = 1'b0;
    if (evt_pulse)                            stat_d = 1'b1;
  end

  always_ff @(posedge clk_bus or negedge rst_bus_n) begin
    if (!rst_bus_n)   run_q <= 1'b0;
    else if (wr_ctrl) run_q <= run_d;
  end

  always_ff @(posedge clk_bus or negedge rst_bus_n) begin
    if (!rst_bus_n)    irqen_q <= 1'b0;
    else if (wr_irqen) irqen_q <= irqen_d;
  end

  always_ff @(posedge clk_bus or negedge rst_bus_n) begin
    if (!rst_bus_n) begin
      stat_q     <= 1'b0;
      evt_prev_q <= 1'b0;
    end else begin
      stat_q     <= stat_d;
      evt_prev_q <= evt_sync;
    end
  end

  // timer domain
  logic          run_tmr;
  logic [DW-1:0] snap_val;
  logic          hit_tgl;

  st_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_run_sync (
    .clk(clk_tmr), .rst_n(rst_tmr_n), .d(run_q), .q(run_tmr));

  st_tick_core #(.DATA_W(DW)) u_core (
    .clk(clk_tmr), .rst_n(rst_tmr_n), .run_i(run_tmr),
    .load_i(load_commit), .load_val_i(load_sh_q),
    .cmp_load_i(match_commit), .cmp_val_i(match_sh_q),
    .snap_i(snap_commit), .snap_o(snap_val), .hit_tgl_o(hit_tgl));

  st_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_evt_sync (
    .clk(clk_bus), .rst_n(rst_bus_n), .d(hit_tgl), .q(evt_sync));

  // read mux
  logic [DW-1:0] rdata_mux;
  always_comb begin
    rdata_mux = '0;
    case (bus_addr)
      OFS_MATCH:  rdata_mux = match_sh_q;
      OFS_COUNT:  rdata_mux = snap_val;
      OFS_STATUS: rdata_mux[STAT_HIT_BIT] = stat_q;
      OFS_IRQEN:  rdata_mux[0] = irqen_q;
      OFS_CTRL:   rdata_mux[CTRL_RUN_BIT] = run_q;
      OFS_ACCESS: begin
        rdata_mux[ACC_MATCH_BIT] = match_busy;
        rdata_mux[ACC_LOAD_BIT]  = load_busy;
        rdata_mux[ACC_SNAP_BIT]  = snap_busy;
      end
      default: rdata_mux = '0;
    endcase
  end

  assign bus_rdata = bus_rd ? rdata_mux : '0;
  assign irq       = stat_q & irqen_q;

  assert_snap_busy_R4: assert property (
    @(posedge clk_bus) disable iff (!rst_bus_n)
    (snap_req && !snap_busy) |=> snap_busy);

  assert_match_locked_R7: assert property (
    @(posedge clk_bus) disable iff (!rst_bus_n)
    (wr_match && match_busy) |=> $stable(match_sh_q));

  assert_load_locked_R7: assert property (
    @(posedge clk_bus) disable iff (!rst_bus_n)
    (wr_count && load_busy) |=> $stable(load_sh_q));

  assert_status_sticky_R8: assert property (
    @(posedge clk_bus) disable iff (!rst_bus_n)
    (stat_q && !wr_status) |=> stat_q);

  assert_status_clear_R9: assert property (
    @(posedge clk_bus) disable iff (!rst_bus_n)
    (wr_status && bus_wdata[STAT_HIT_BIT] && !evt_pulse) |=> !stat_q);

  assert_irq_gated_R10: assert property (
    @(posedge clk_bus) disable iff (!rst_bus_n)
    (!irqen_q && !wr_irqen) |=> !irq);
endmodule

// File: tb/tb_sync_timer.sv
`timescale 1ns/1ps
module tb_sync_timer;
  localparam int CLK_PERIOD = 10;
  localparam int TMR_PERIOD = 26;
  localparam int WATCHDOG   = 150000;

  logic        clk_bus = 1'b0;
  logic        clk_tmr = 1'b0;
  logic        rst_n   = 1'b0;
  logic        bus_wr  = 1'b0;
  logic        bus_rd  = 1'b0;
  logic [5:0]  bus_addr  = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit m_ier    = 1'b0;   // model of the interrupt-enable bit
  bit live     = 1'b0;

  always #(CLK_PERIOD/2) clk_bus = ~clk_bus;
  always #(TMR_PERIOD/2) clk_tmr = ~clk_tmr;

  sync_timer dut (
    .clk_bus(clk_bus), .clk_tmr(clk_tmr), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model: no interrupt while enable is off (R10)
  always @(negedge clk_bus) begin
    if (live) begin
      #2;
      check(!(!m_ier && irq), "R10 per-cycle", {31'b0, irq}, 32'h0);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_bus);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk_bus);
    bus_wr = 1'b0;
    if (a == 6'h1C) m_ier = d[0];
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk_bus);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle(input int bitn, input string req);
    logic [31:0] v;
    int k;
    k = 0;
    do begin
      rd(6'h24, v);
      k++;
    end while (v[bitn] && k < 400);
    check(!v[bitn], req, v, 32'h0);
  endtask

  task automatic snap(input bit run, output logic [31:0] v);
    logic [31:0] a;
    wr(6'h20, {30'b0, 1'b1, run});
    rd(6'h24, a);
    check(a[5], "R4 capture busy", {31'b0, a[5]}, 32'h1);
    wait_idle(5, "R4 capture done");
    rd(6'h10, v);
  endtask

  task automatic wait_hit(output logic [31:0] s);
    int k;
    k = 0;
    do begin
      rd(6'h14, s);
      k++;
    end while (!s[0] && k < 600);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_bus);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", WATCHDOG, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, v1, v2, a, b, base;
    repeat (5) @(negedge clk_bus);
    rst_n = 1'b1;
    repeat (10) @(negedge clk_bus);
    live = 1'b1;

    // R1 reset values
    rd(6'h00, v); check(v == 32'hFFFF_FFFF, "R1 match", v, 32'hFFFF_FFFF);
    rd(6'h20, v); check(v == 0, "R1 ctrl", v, 0);
    rd(6'h14, v); check(v == 0, "R1 status", v, 0);
    rd(6'h1C, v); check(v == 0, "R1 irqen", v, 0);
    rd(6'h24, v); check(v == 0, "R1 access", v, 0);
    rd(6'h10, v); check(v == 0, "R1 counter", v, 0);

    // R5 counter load, then R4 capture while stopped
    base = 32'h1234_5678;
    wr(6'h10, base);
    rd(6'h24, v); check(v[4], "R5 load busy", v, 32'h10);
    wait_idle(4, "R5 load done");
    snap(1'b0, v); check(v == base, "R5 loaded value", v, base);

    // R2 hold while stopped
    repeat (60) @(negedge clk_bus);
    snap(1'b0, v); check(v == base, "R2 hold", v, base);

    // R2 counting
    wr(6'h20, 32'h1);
    repeat (200) @(negedge clk_bus);
    snap(1'b1, v1);
    check((v1 - base) >= 50 && (v1 - base) <= 120, "R2 count rate", v1 - base, 32'd80);
    repeat (50) @(negedge clk_bus);
    snap(1'b1, v2);
    check(v2 > v1, "R2 advancing", v2, v1 + 1);
    wr(6'h20, 32'h0);
    repeat (20) @(negedge clk_bus);
    snap(1'b0, a);
    repeat (80) @(negedge clk_bus);
    snap(1'b0, b);
    check(a == b, "R2 stopped", b, a);

    // R3 wrap
    wr(6'h10, 32'hFFFF_FFF0);
    wait_idle(4, "R5 load done");
    wr(6'h20, 32'h1);
    repeat (100) @(negedge clk_bus);
    snap(1'b1, v);
    check(v < 32'h100, "R3 wrap", v, 32'h20);
    wr(6'h20, 32'h0);
    repeat (20) @(negedge clk_bus);

    // R6 compare write, R8 event, R9 clear, R10 gating
    wr(6'h14, 32'hF);
    rd(6'h14, v); check(v == 0, "R9 clear after wrap hit", v, 0);
    wr(6'h10, 32'd1000);
    wait_idle(4, "R5 load done");
    wr(6'h00, 32'd1030);
    rd(6'h24, v); check(v[0], "R6 match busy", v, 32'h1);
    wait_idle(0, "R6 match done");
    rd(6'h00, v); check(v == 32'd1030, "R6 readback", v, 32'd1030);
    wr(6'h20, 32'h1);
    wait_hit(v);
    check(v == 32'h1, "R8 status set", v, 32'h1);
    check(irq == 1'b0, "R10 masked", {31'b0, irq}, 0);
    snap(1'b1, v);
    check(v >= 32'd1030 && v < 32'd1300, "R8 hit point", v, 32'd1030);
    wr(6'h20, 32'h0);
    repeat (20) @(negedge clk_bus);
    rd(6'h14, v); check(v == 32'h1, "R8 sticky", v, 32'h1);
    wr(6'h14, 32'h0);
    rd(6'h14, v); check(v == 32'h1, "R9 zero write no effect", v, 32'h1);
    wr(6'h1C, 32'h1);
    #1; check(irq == 1'b1, "R10 enabled", {31'b0, irq}, 32'h1);
    wr(6'h14, 32'hF);
    #1; check(irq == 1'b0, "R9 irq dropped", {31'b0, irq}, 0);
    rd(6'h14, v); check(v == 0, "R9 cleared", v, 0);

    // R7 second compare write while busy is dropped
    wr(6'h00, 32'd5000);
    wr(6'h00, 32'd7000);
    wait_idle(0, "R6 match done");
    rd(6'h00, v); check(v == 32'd5000, "R7 match kept", v, 32'd5000);
    wr(6'h10, 32'd4990);
    wait_idle(4, "R5 load done");
    wr(6'h20, 32'h1);
    wait_hit(v);
    check(v == 32'h1, "R7 hit at first value", v, 32'h1);
    #1; check(irq == 1'b1, "R10 raised", {31'b0, irq}, 32'h1);
    snap(1'b1, v);
    check(v >= 32'd5000 && v < 32'd5300, "R7 committed compare", v, 32'd5000);
    wr(6'h20, 32'h0);
    wr(6'h14, 32'hF);
    repeat (20) @(negedge clk_bus);

    // R7 second counter load while busy is dropped
    wr(6'h10, 32'd100);
    wr(6'h10, 32'd200);
    wait_idle(4, "R5 load done");
    snap(1'b0, v); check(v == 32'd100, "R7 load kept", v, 32'd100);

    // R7 second capture request while busy is dropped; capture still valid
    wr(6'h20, 32'h2);
    wr(6'h20, 32'h2);
    wait_idle(5, "R7 capture done");
    rd(6'h10, v); check(v == 32'd100, "R7 capture value", v, 32'd100);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule